// File: doc/BRIEF.md
# Dual-Map GPIB Register Select Decoder

This block sits between a host bus and the register file of a GPIB talker/listener controller that can present either of two legacy register layouts. Each host access carries a 5-bit offset and a read or write strobe. One clock later the block answers with a one-hot select naming the single internal register that the access reaches, a valid flag, and a write qualifier. The registers themselves live elsewhere. An offset that reaches nothing selects nothing, so the surrounding data path returns zero on such a read.

The layout in force is held in an emulation-mode bit. The bit is loaded from a strap pin while reset is held, and software can change it afterwards with auxiliary commands. Map A is a straightforward layout. Map B has extra features:

- a swap input that moves its data and auxiliary-command registers to the positions they hold in map A;
- a page-in state that opens otherwise unreachable registers;
- a hardware page pin.

Auxiliary commands set and clear the page-in state. Twelve offsets in the upper part of the space belong to a shared transfer engine and decode identically in both maps.

Top module: `emu_regmap_dec`

## Requirements
- R1: While `rst` is high, the mode bit loads the inverse of `mode_pin`: `mode_pin`=1 gives map A (`mode_b`=0) and `mode_pin`=0 gives map B (`mode_b`=1). Reset also clears the page-in state and the select outputs.
- R2: In map A, even offsets 0x00–0x0E select, for reads and writes respectively:
  - 0: data-in / command-out
  - 2: int-status-1 / int-mask-1
  - 4: int-status-2 / int-mask-2
  - 6: poll-status / poll-mode
  - 8: addr-status / addr-mode
  - A: cmd-pass / aux-command
  - C: addr-read-0 / addr-write
  - E: addr-read-1 / end-of-string
- R3: The shared offsets decode the same way in both maps, for reads and writes respectively:
  - 0x09: count-2 (both)
  - 0x0B: count-3 (both)
  - 0x0D: speed-select (write only; reads select nothing)
  - 0x10: status-1 / config
  - 0x12: int-mask-3 (both)
  - 0x14: count-0 (both)
  - 0x16: count-1 (both)
  - 0x18: fifo-B (both)
  - 0x19: fifo-A (both)
  - 0x1A: int-status-3 / clock-config
  - 0x1C: status-2 / command
  - 0x1E: timer (both)
- R4: Any other offset is reserved. It drives an all-zero select with `sel_vld`=0, and a valid select is always one-hot.
- R5: A cycle with no strobe produces no select. When both strobes are high in the same cycle, the access is treated as a write. The select appears in the cycle after the strobe.
- R6: A write to the aux-command register (0x0A in map A; in map B, 0x06 unswapped or 0x0A swapped) with data 0x5A selects map A, and with data 0x5B selects map B. The new mode applies from the next access.
- R7: In map B with `swap_en`=0, the even offsets select, for reads and writes respectively:
  - 0: int-status-0 / int-mask-0
  - 2: int-status-1 / int-mask-1
  - 4: addr-status / nothing (when no page is active)
  - 6: bus-status / aux-command
  - 8: int-status-2 / address
  - A: poll-status / poll-mode
  - C: cmd-pass / parallel-poll
  - E: data-in / command-out
- R8: In map B with `swap_en`=1, the registers move as follows:
  - data-in / command-out go to 0x00;
  - cmd-pass / parallel-poll go to 0x02;
  - poll-status / poll-mode go to 0x04;
  - int-status-2 / address go to 0x06;
  - the addr-status location goes to 0x08;
  - bus-status / aux-command go to 0x0A;
  - int-status-0 / int-mask-0 go to 0x0C;
  - int-status-1 / int-mask-1 go to 0x0E.
- R9: In map B, an aux-command write of 0x50+k (k=0..3) activates page k. While the page is active, writes at the addr-status location select paged register k: 0 = int-mask-2, 1 = end-of-string, 2 = byte-count, 3 = access-config.
- R10: While any page is active in map B, reads at 0x11 select int-status-2 and reads at 0x13 select poll-status. Otherwise these offsets are reserved.
- R11: The aux command 0x54 clears the page-in state. After it, the paged registers and the 0x11/0x13 aliases are unreachable again.
- R12: In map B, `pg_pin`=1 with no commanded page acts as page 0 (int-mask-2). In map A, `pg_pin` has no effect.
- R13: The page-in state can be active only in map B. It is cleared on every mode change, and page commands issued in map A are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_pin | input | 1 | Strap sampled during reset: 1 = map A, 0 = map B |
| swap_en | input | 1 | Map B swapped layout enable |
| pg_pin | input | 1 | Hardware page-in request (map B only) |
| offset | input | 5 | Register offset of the access |
| rd_stb | input | 1 | Read strobe, one cycle per access |
| wr_stb | input | 1 | Write strobe, one cycle per access |
| wr_data | input | 8 | Write data, decoded when it targets the aux-command register |
| sel_onehot | output | 51 | One-hot register select, bit index = register code |
| sel_vld | output | 1 | The access reached a register |
| sel_wr | output | 1 | The valid access was a write |
| mode_b | output | 1 | Current emulation map: 0 = A, 1 = B |

## Verification
The scoreboard targets the locations whose meaning depends on state.

The addr-status location is written with and without a page active, and in both the plain and the swapped layout. A design that ignores the page state, or keys it to the wrong offset, writes a paged register when it should write nothing, or the reverse.

The page is opened, the mode is switched away and back, and the location is probed again. A design that keeps a stale page across a mode change would still reach a paged register here.

Reserved offsets, the 0x11/0x13 aliases outside a page, and page commands issued in map A are all probed. A design that decodes them would raise `sel_vld`.

Simultaneous strobes and the reset strap in both polarities are also checked.

// File: rtl/emu_regmap_pkg.sv
package emu_regmap_pkg;

    typedef enum logic [5:0] {
        RG_NONE,
        RG_A_DIN, RG_A_CMDOUT, RG_A_IST1, RG_A_IMSK1, RG_A_IST2, RG_A_IMSK2,
        RG_A_SPST, RG_A_SPMD, RG_A_ADST, RG_A_ADMD, RG_A_CPASS, RG_A_AUX,
        RG_A_ADRD0, RG_A_ADWR, RG_A_ADRD1, RG_A_EOS,
        RG_B_IST0, RG_B_IMSK0, RG_B_IST1, RG_B_IMSK1, RG_B_ADST, RG_B_BUSST,
        RG_B_AUX, RG_B_IST2, RG_B_ADDR, RG_B_SPST, RG_B_SPMD, RG_B_CPASS,
        RG_B_PPOLL, RG_B_DIN, RG_B_CMDOUT,
        RG_B_PG_IMSK2, RG_B_PG_EOS, RG_B_PG_BCNT, RG_B_PG_ACC,
        RG_S_CNT0, RG_S_CNT1, RG_S_CNT2, RG_S_CNT3, RG_S_HSPD, RG_S_STAT1,
        RG_S_CFG, RG_S_IMSK3, RG_S_FIFOB, RG_S_FIFOA, RG_S_IST3, RG_S_CLKCFG,
        RG_S_STAT2, RG_S_CMD, RG_S_TIMER
    } reg_id_e;

    localparam int RID_COUNT = int'(RG_S_TIMER) + 1;
    localparam int OFF_W     = 5;
    localparam int CMD_W     = 8;

    localparam logic [CMD_W-1:0] AUXC_PAGE_BASE = 8'h50;
    localparam logic [CMD_W-1:0] AUXC_PAGE_CLR  = 8'h54;
    localparam logic [CMD_W-1:0] AUXC_MODE_A    = 8'h5A;
    localparam logic [CMD_W-1:0] AUXC_MODE_B    = 8'h5B;

    typedef struct packed {
        logic       mode_b;
        logic       swap;
        logic       pg_on;
        logic [1:0] pg_idx;
    } map_state_t;

    function automatic reg_id_e rw_pick(input logic is_wr, input reg_id_e r, input reg_id_e w);
        return is_wr ? w : r;
    endfunction

    // Swapped map B slot to canonical slot (slot = offset[3:1])
    function automatic logic [2:0] swap_slot(input logic [2:0] s);
        case (s)
            3'd0: return 3'd7;
            3'd1: return 3'd6;
            3'd2: return 3'd5;
            3'd3: return 3'd4;
            3'd4: return 3'd2;
            3'd5: return 3'd3;
            3'd6: return 3'd0;
            default: return 3'd1;
        endcase
    endfunction

    function automatic reg_id_e shared_lookup(input logic is_wr, input logic [OFF_W-1:0] off);
        case (off)
            5'h09: return RG_S_CNT2;
            5'h0B: return RG_S_CNT3;
            5'h0D: return is_wr ? RG_S_HSPD : RG_NONE;
            5'h10: return rw_pick(is_wr, RG_S_STAT1, RG_S_CFG);
            5'h12: return RG_S_IMSK3;
            5'h14: return RG_S_CNT0;
            5'h16: return RG_S_CNT1;
            5'h18: return RG_S_FIFOB;
            5'h19: return RG_S_FIFOA;
            5'h1A: return rw_pick(is_wr, RG_S_IST3, RG_S_CLKCFG);
            5'h1C: return rw_pick(is_wr, RG_S_STAT2, RG_S_CMD);
            5'h1E: return RG_S_TIMER;
            default: return RG_NONE;
        endcase
    endfunction

    function automatic reg_id_e map_a_lookup(input logic is_wr, input logic [2:0] slot);
        case (slot)
            3'd0: return rw_pick(is_wr, RG_A_DIN,   RG_A_CMDOUT);
            3'd1: return rw_pick(is_wr, RG_A_IST1,  RG_A_IMSK1);
            3'd2: return rw_pick(is_wr, RG_A_IST2,  RG_A_IMSK2);
            3'd3: return rw_pick(is_wr, RG_A_SPST,  RG_A_SPMD);
            3'd4: return rw_pick(is_wr, RG_A_ADST,  RG_A_ADMD);
            3'd5: return rw_pick(is_wr, RG_A_CPASS, RG_A_AUX);
            3'd6: return rw_pick(is_wr, RG_A_ADRD0, RG_A_ADWR);
            default: return rw_pick(is_wr, RG_A_ADRD1, RG_A_EOS);
        endcase
    endfunction

    function automatic reg_id_e paged_write(input logic [1:0] idx);
        case (idx)
            2'd0: return RG_B_PG_IMSK2;
            2'd1: return RG_B_PG_EOS;
            2'd2: return RG_B_PG_BCNT;
            default: return RG_B_PG_ACC;
        endcase
    endfunction

    function automatic reg_id_e map_b_lookup(input logic is_wr, input logic [2:0] slot,
                                             input logic pg_on, input logic [1:0] pg_idx);
        case (slot)
            3'd0: return rw_pick(is_wr, RG_B_IST0, RG_B_IMSK0);
            3'd1: return rw_pick(is_wr, RG_B_IST1, RG_B_IMSK1);
            3'd2: return is_wr ? (pg_on ? paged_write(pg_idx) : RG_NONE) : RG_B_ADST;
            3'd3: return rw_pick(is_wr, RG_B_BUSST, RG_B_AUX);
            3'd4: return rw_pick(is_wr, RG_B_IST2, RG_B_ADDR);
            3'd5: return rw_pick(is_wr, RG_B_SPST, RG_B_SPMD);
            3'd6: return rw_pick(is_wr, RG_B_CPASS, RG_B_PPOLL);
            default: return rw_pick(is_wr, RG_B_DIN, RG_B_CMDOUT);
        endcase
    endfunction

endpackage

// File: rtl/map_decode.sv
module map_decode
    import emu_regmap_pkg::*;
(
    input  map_state_t         st,
    input  logic               is_wr,
    input  logic [OFF_W-1:0]   off,
    output reg_id_e            id
);
    localparam logic [OFF_W-1:0] ALIAS_IST2 = 5'h11;
    localparam logic [OFF_W-1:0] ALIAS_SPST = 5'h13;

    logic [2:0] slot_raw;
    logic [2:0] slot_b;
    logic       legacy_area;
    reg_id_e    shared_id;

    assign slot_raw    = off[3:1];
    assign slot_b      = st.swap ? swap_slot(slot_raw) : slot_raw;
    assign legacy_area = !off[OFF_W-1] && !off[0];
    assign shared_id   = shared_lookup(is_wr, off);

    always_comb begin
        id = RG_NONE;
        if (shared_id != RG_NONE) begin
            id = shared_id;
        end else if (legacy_area) begin
            id = st.mode_b ? map_b_lookup(is_wr, slot_b, st.pg_on, st.pg_idx)
                           : map_a_lookup(is_wr, slot_raw);
        end else if (st.mode_b && st.pg_on && !is_wr) begin
            if (off == ALIAS_IST2)      id = RG_B_IST2;
            else if (off == ALIAS_SPST) id = RG_B_SPST;
        end
    end
endmodule

// File: rtl/mode_page_ctl.sv
module mode_page_ctl
    import emu_regmap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_pin,
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_data,
    output logic             mode_b,
    output logic             page_on,
    output logic [1:0]       page_idx
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_b   <= ~mode_pin;
            page_on  <= 1'b0;
            page_idx <= 2'd0;
        end else if (cmd_wr) begin
            if (cmd_data == AUXC_MODE_A && mode_b) begin
                mode_b  <= 1'b0;
                page_on <= 1'b0;
            end else if (cmd_data == AUXC_MODE_B && !mode_b) begin
                mode_b  <= 1'b1;
                page_on <= 1'b0;
            end else if (cmd_data == AUXC_PAGE_CLR) begin
                page_on <= 1'b0;
            end else if (mode_b && cmd_data[CMD_W-1:2] == AUXC_PAGE_BASE[CMD_W-1:2]) begin
                page_on  <= 1'b1;
                page_idx <= cmd_data[1:0];
            end
        end
    end

    p_page_only_b_r13: assert property (@(posedge clk) disable iff (rst)
        page_on |-> mode_b);

    p_mode_change_clears_r13: assert property (@(posedge clk) disable iff (rst)
        !$stable(mode_b) |-> !page_on);

    p_clear_cmd_r11: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && cmd_data == AUXC_PAGE_CLR) |=> !page_on);
endmodule

// File: rtl/sel_stage.sv
module sel_stage
    import emu_regmap_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 acc,
    input  logic                 is_wr,
    input  reg_id_e              id,
    output logic [RID_COUNT-1:0] sel_onehot,
    output logic                 sel_vld,
    output logic                 sel_wr
);
    logic hit;
    assign hit = acc && (id != RG_NONE);

    assign sel_onehot[0] = 1'b0;
    for (genvar k = 1; k < RID_COUNT; k++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) sel_onehot[k] <= 1'b0;
            else     sel_onehot[k] <= hit && (int'(id) == k);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_vld <= 1'b0;
            sel_wr  <= 1'b0;
        end else begin
            sel_vld <= hit;
            sel_wr  <= hit && is_wr;
        end
    end

    p_onehot_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel_onehot));

    p_vld_matches_r4: assert property (@(posedge clk) disable iff (rst)
        sel_vld == (sel_onehot != '0));

    p_idle_r5: assert property (@(posedge clk) disable iff (rst)
        !acc |=> !sel_vld);

    p_wr_qual_r5: assert property (@(posedge clk) disable iff (rst)
        sel_wr |-> sel_vld);
endmodule

// File: rtl/emu_regmap_dec.sv
module emu_regmap_dec
    import emu_regmap_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 mode_pin,
    input  logic                 swap_en,
    input  logic                 pg_pin,
    input  logic [4:0]           offset,
    input  logic                 rd_stb,
    input  logic                 wr_stb,
    input  logic [7:0]           wr_data,
    output logic [50:0]          sel_onehot,
    output logic                 sel_vld,
    output logic                 sel_wr,
    output logic                 mode_b
);
    logic       page_on;
    logic [1:0] page_idx;
    map_state_t st;
    reg_id_e    id;
    logic       acc;
    logic       cmd_wr;

    assign acc = rd_stb || wr_stb;

    // Hardware page pin acts as page 0 when no commanded page is open
    assign st.mode_b = mode_b;
    assign st.swap   = swap_en;
    assign st.pg_on  = mode_b && (page_on || pg_pin);
    assign st.pg_idx = page_on ? page_idx : 2'd0;

    map_decode u_dec (
        .st    (st),
        .is_wr (wr_stb),
        .off   (offset),
        .id    (id)
    );

    assign cmd_wr = wr_stb && (id == RG_A_AUX || id == RG_B_AUX);

    mode_page_ctl u_ctl (
        .clk      (clk),
        .rst      (rst),
        .mode_pin (mode_pin),
        .cmd_wr   (cmd_wr),
        .cmd_data (wr_data),
        .mode_b   (mode_b),
        .page_on  (page_on),
        .page_idx (page_idx)
    );

    sel_stage u_sel (
        .clk        (clk),
        .rst        (rst),
        .acc        (acc),
        .is_wr      (wr_stb),
        .id         (id),
        .sel_onehot (sel_onehot),
        .sel_vld    (sel_vld),
        .sel_wr     (sel_wr)
    );

    p_reserved_r4: assert property (@(posedge clk) disable iff (rst)
        (acc && offset inside {5'h01, 5'h03, 5'h05, 5'h07, 5'h0F}) |=> !sel_vld);

    p_mode_a_no_alias_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && !wr_stb && !mode_b && offset == 5'h11) |=> !sel_vld);
endmodule

// File: tb/emu_regmap_dec_tb_top.sv
module emu_regmap_dec_tb_top;
    import emu_regmap_pkg::*;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_pin = 1'b1;
    logic        swap_en = 1'b0;
    logic        pg_pin = 1'b0;
    logic [4:0]  offset = '0;
    logic        rd_stb = 1'b0;
    logic        wr_stb = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [50:0] sel_onehot;
    logic        sel_vld;
    logic        sel_wr;
    logic        mode_b;

    int checks = 0;
    int failures = 0;

    typedef struct {
        reg_id_e exp_id;
        logic    exp_wr;
        string   tag;
    } exp_item_t;

    exp_item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    emu_regmap_dec dut_i (
        .clk(clk), .rst(rst), .mode_pin(mode_pin), .swap_en(swap_en),
        .pg_pin(pg_pin), .offset(offset), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .wr_data(wr_data), .sel_onehot(sel_onehot), .sel_vld(sel_vld),
        .sel_wr(sel_wr), .mode_b(mode_b)
    );

    // Monitor: pops one expectation per clock after the edge that registers it
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_item_t it;
            logic [50:0] ev;
            logic        evld;
            it   = sb_q.pop_front();
            ev   = '0;
            evld = (it.exp_id != RG_NONE);
            if (evld) ev[int'(it.exp_id)] = 1'b1;
            checks++;
            if (sel_onehot !== ev || sel_vld !== evld || sel_wr !== (evld && it.exp_wr)) begin
                failures++;
                $display("FAIL %s: sel=%h vld=%b wr=%b expected sel=%h vld=%b wr=%b",
                         it.tag, sel_onehot, sel_vld, sel_wr, ev, evld, evld && it.exp_wr);
            end
        end
    end

    task automatic acc(input logic [4:0] off, input logic rd, input logic wr,
                       input logic [7:0] d, input reg_id_e exp, input string tag);
        exp_item_t it;
        @(negedge clk);
        offset = off; rd_stb = rd; wr_stb = wr; wr_data = d;
        it.exp_id = exp; it.exp_wr = wr; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        rd_stb = 1'b0; wr_stb = 1'b0;
    endtask

    task automatic rdx(input logic [4:0] off, input reg_id_e exp, input string tag);
        acc(off, 1'b1, 1'b0, 8'h00, exp, tag);
    endtask

    task automatic wrx(input logic [4:0] off, input logic [7:0] d, input reg_id_e exp, input string tag);
        acc(off, 1'b0, 1'b1, d, exp, tag);
    endtask

    task automatic chk_mode(input logic exp, input string tag);
        checks++;
        if (mode_b !== exp) begin
            failures++;
            $display("FAIL %s: mode_b=%b expected %b", tag, mode_b, exp);
        end
    endtask

    task automatic do_reset(input logic pin);
        @(negedge clk);
        rst = 1'b1; mode_pin = pin;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: strap high gives map A, outputs idle
        do_reset(1'b1);
        chk_mode(1'b0, "R1 strap high");
        checks++;
        if (sel_vld !== 1'b0 || sel_onehot !== '0) begin
            failures++;
            $display("FAIL R1 reset select: vld=%b sel=%h expected 0", sel_vld, sel_onehot);
        end

        // R2: map A layout
        rdx(5'h00, RG_A_DIN,    "R2 A rd 0");
        wrx(5'h00, 8'h00, RG_A_CMDOUT, "R2 A wr 0");
        rdx(5'h04, RG_A_IST2,   "R2 A rd 4");
        rdx(5'h0C, RG_A_ADRD0,  "R2 A rd C");
        wrx(5'h0E, 8'h00, RG_A_EOS, "R2 A wr E");
        wrx(5'h0A, 8'h00, RG_A_AUX, "R2 A wr A");

        // R3: shared offsets in map A
        rdx(5'h18, RG_S_FIFOB,  "R3 A fifoB");
        wrx(5'h0D, 8'h00, RG_S_HSPD, "R3 A speed wr");
        rdx(5'h0D, RG_NONE,     "R3 A speed rd");
        wrx(5'h10, 8'h00, RG_S_CFG, "R3 A cfg");

        // R4: reserved offsets
        rdx(5'h01, RG_NONE, "R4 rd 01");
        wrx(5'h0F, 8'h00, RG_NONE, "R4 wr 0F");
        rdx(5'h1F, RG_NONE, "R4 rd 1F");
        // R10: alias absent in map A
        rdx(5'h11, RG_NONE, "R10 A 11");

        // R5: idle cycle and simultaneous strobes
        begin
            exp_item_t it;
            @(negedge clk);
            it.exp_id = RG_NONE; it.exp_wr = 1'b0; it.tag = "R5 idle";
            offset = 5'h00;
            sb_q.push_back(it);
        end
        acc(5'h02, 1'b1, 1'b1, 8'h00, RG_A_IMSK1, "R5 both strobes");

        // R13: page command in map A is ignored
        wrx(5'h0A, 8'h50, RG_A_AUX, "R13 page cmd in A");

        // R6: switch to map B
        wrx(5'h0A, 8'h5B, RG_A_AUX, "R6 to B");
        chk_mode(1'b1, "R6 mode B");
        wrx(5'h04, 8'h00, RG_NONE, "R13 A page ignored");

        // R7: unswapped map B
        rdx(5'h00, RG_B_IST0,  "R7 B rd 0");
        rdx(5'h04, RG_B_ADST,  "R7 B rd 4");
        wrx(5'h04, 8'h00, RG_NONE, "R7 B wr 4 none");
        wrx(5'h06, 8'h00, RG_B_AUX, "R7 B wr 6");
        rdx(5'h0E, RG_B_DIN,   "R7 B rd E");
        rdx(5'h1C, RG_S_STAT2, "R3 B stat2");

        // R8: swapped map B
        swap_en = 1'b1;
        rdx(5'h00, RG_B_DIN,    "R8 swap rd 0");
        wrx(5'h00, 8'h00, RG_B_CMDOUT, "R8 swap wr 0");
        rdx(5'h06, RG_B_IST2,   "R8 swap rd 6");
        rdx(5'h08, RG_B_ADST,   "R8 swap rd 8");
        wrx(5'h08, 8'h00, RG_NONE, "R8 swap wr 8 none");
        rdx(5'h0C, RG_B_IST0,   "R8 swap rd C");

        // R9/R10: page in end-of-string register
        rdx(5'h13, RG_NONE, "R10 no page 13");
        wrx(5'h0A, 8'h51, RG_B_AUX, "R9 page 1 cmd");
        wrx(5'h08, 8'h00, RG_B_PG_EOS, "R9 paged eos");
        rdx(5'h08, RG_B_ADST, "R9 paged rd stays");
        rdx(5'h11, RG_B_IST2, "R10 alias 11");
        rdx(5'h13, RG_B_SPST, "R10 alias 13");
        wrx(5'h0A, 8'h53, RG_B_AUX, "R9 page 3 cmd");
        wrx(5'h08, 8'h00, RG_B_PG_ACC, "R9 paged acc");

        // R11: clear page
        wrx(5'h0A, 8'h54, RG_B_AUX, "R11 clear cmd");
        wrx(5'h08, 8'h00, RG_NONE, "R11 paged gone");
        rdx(5'h11, RG_NONE, "R11 alias gone");

        // R12: hardware page pin
        swap_en = 1'b0;
        pg_pin  = 1'b1;
        wrx(5'h04, 8'h00, RG_B_PG_IMSK2, "R12 pin page");
        rdx(5'h13, RG_B_SPST, "R12 pin alias");
        pg_pin  = 1'b0;

        // R13: mode change clears page
        wrx(5'h06, 8'h52, RG_B_AUX, "R13 page 2 cmd");
        wrx(5'h04, 8'h00, RG_B_PG_BCNT, "R13 paged bcnt");
        wrx(5'h06, 8'h5A, RG_B_AUX, "R13 to A");
        chk_mode(1'b0, "R6 back to A");
        pg_pin = 1'b1;
        wrx(5'h04, 8'h00, RG_A_IMSK2, "R12 pin ignored in A");
        pg_pin = 1'b0;
        wrx(5'h0A, 8'h5B, RG_A_AUX, "R13 to B again");
        wrx(5'h04, 8'h00, RG_NONE, "R13 page cleared");

        // R1: strap low gives map B, page cleared
        wrx(5'h06, 8'h50, RG_B_AUX, "R1 pre-page");
        do_reset(1'b0);
        chk_mode(1'b1, "R1 strap low");
        wrx(5'h04, 8'h00, RG_NONE, "R1 page cleared");

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule